// File: doc/BRIEF.md
# Four-Thread Context Scheduler

This block keeps the per-thread context of a small packet engine that interleaves four hardware threads. Each thread has its own program counter and its own bank of general-purpose registers. A single running thread owns the engine until it issues a memory request or gives up its turn. When it does, the scheduler chooses the next ready thread and puts it on the fetch port on the very next cycle. The memory latency of the thread that left is therefore covered by useful work from another thread.

The threads that are ready are served in round-robin order. The search starts just after the thread that last held the engine. If no thread is ready, the engine sits with no thread running. A waiting thread becomes ready again when a memory-done strobe tagged with its number arrives. Software-side setup goes through a load strobe, which gives an idle thread a start address and makes it ready.

The register port offers two addressing modes. In local mode, a 5-bit register number selects a register in the running thread's bank. In global mode, a 7-bit address selects any of the 128 physical registers, so every thread sees the same shared storage.

Top module: `ctx_sched`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `run_valid` is 0 and every thread is idle.
- R2: A load strobe to an idle thread sets that thread's PC to `ld_pc` and makes it ready. A load to a thread that is not idle is ignored, and its PC keeps its value.
- R3: With no thread running, a thread that becomes ready at one clock edge is running after the next edge, and `fetch_pc` shows its PC.
- R4: A `step` pulse on a running thread with no `mreq` and no `yld` raises its PC by one.
- R5: An `mreq` from the running thread puts it into the waiting state. In the cycle after the request, the next ready thread runs: the search goes in round-robin order from the thread after the requester and wraps around.
- R6: A thread that was swapped out resumes at the PC of its request instruction plus one.
- R7: An `mreq` when no other thread is ready leaves `run_valid` at 0 until a thread becomes ready again.
- R8: `yld` makes the running thread ready with PC+1 and starts the next ready thread in round-robin order. If no other thread is ready, the same thread continues with no idle cycle.
- R9: A memory-done strobe tagged with a thread that is not waiting has no effect.
- R10: In local mode (mode bit 0), register address bits [4:0] select an entry in the running thread's bank at physical index {thread, addr[4:0]}. Threads do not see each other's local registers.
- R11: In global mode (mode bit 1), the full 7-bit address selects the physical register directly. A global write is seen on the next read by every thread, including a local read of the same physical entry.
- R12: Read data is registered. The address presented before a clock edge gives `rd_data` after that edge.
- R13: Scheduling is non-preemptive. While neither `mreq` nor `yld` is asserted, the running thread keeps the engine, even when other threads are ready.
- R14: The PC is 11 bits wide and wraps from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load strobe for an idle thread |
| ld_tid | input | 2 | Thread being loaded |
| ld_pc | input | 11 | Start PC for the loaded thread |
| mdone_valid | input | 1 | Memory completion strobe |
| mdone_tid | input | 2 | Thread whose memory access completed |
| mreq | input | 1 | Running thread issues a memory request |
| yld | input | 1 | Running thread gives up the engine |
| step | input | 1 | Running thread retires an ordinary instruction |
| run_valid | output | 1 | A thread is running |
| run_tid | output | 2 | Running thread number |
| fetch_pc | output | 11 | Instruction fetch address of the running thread |
| rd_addr | input | 7 | Register read address |
| rd_glb | input | 1 | Read mode: 1 global, 0 local |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 7 | Register write address |
| wr_glb | input | 1 | Write mode: 1 global, 0 local |
| wr_data | input | 32 | Register write data |

## Verification
The properties check several rules on every cycle: reset clears the engine, a thread keeps running without a request, the PC advances by one and wraps, a memory request always hands the engine to a different thread or to none, and a yield never leaves an idle cycle. The directed scenarios are the only way to show the rest. These are the exact round-robin choice among several ready threads, the resume address after a wait, the ignored load and done strobes, and the mapping of local and global register addresses, including a global write aliased onto another thread's bank.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    TH_IDLE  = 2'd0,
    TH_READY = 2'd1,
    TH_RUN   = 2'd2,
    TH_WAIT  = 2'd3
  } th_state_e;
endpackage

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
  parameter int NTHR = 4,
  localparam int TIDW = $clog2(NTHR)
) (
  input  logic [NTHR-1:0] req,
  input  logic [TIDW-1:0] last,
  output logic            found,
  output logic [TIDW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = last;
    for (int k = 1; k <= NTHR; k++) begin
      logic [TIDW-1:0] cand;
      cand = TIDW'((int'(last) + k) % NTHR);
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/ctx_thread_tbl.sv
module ctx_thread_tbl
  import ctx_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int PCW  = 11,
  localparam int TIDW = $clog2(NTHR)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_valid,
  input  logic [TIDW-1:0]           ld_tid,
  input  logic [PCW-1:0]            ld_pc,
  input  logic                      done_valid,
  input  logic [TIDW-1:0]           done_tid,
  input  logic [TIDW-1:0]           cur,
  input  logic                      mreq_g,
  input  logic                      yld_g,
  input  logic                      step_g,
  input  logic                      launch,
  input  logic [TIDW-1:0]           sel_idx,
  output logic [NTHR-1:0]           ready,
  output logic [NTHR-1:0][PCW-1:0]  pcs
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    th_state_e      st;
    logic [PCW-1:0] pc;
    logic           is_cur;

    assign is_cur   = (cur == TIDW'(t));
    assign ready[t] = (st == TH_READY);
    assign pcs[t]   = pc;

    always_ff @(posedge clk) begin
      if (rst) begin
        st <= TH_IDLE;
        pc <= '0;
      end else begin
        unique case (st)
          TH_IDLE: if (ld_valid && ld_tid == TIDW'(t)) begin
            st <= TH_READY;
            pc <= ld_pc;
          end
          TH_WAIT: if (done_valid && done_tid == TIDW'(t)) st <= TH_READY;
          TH_RUN: if (is_cur) begin
            if (mreq_g) begin
              st <= TH_WAIT;
              pc <= pc + 1'b1;
            end else if (yld_g) begin
              st <= TH_READY;
              pc <= pc + 1'b1;
            end else if (step_g) begin
              pc <= pc + 1'b1;
            end
          end
          default: ;
        endcase
        if (launch && sel_idx == TIDW'(t)) st <= TH_RUN;
      end
    end
  end
endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
  parameter int DW = 32,
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched #(
  parameter int NTHR     = 4,
  parameter int PCW      = 11,
  parameter int DW       = 32,
  parameter int REGS_PER = 32,
  localparam int TIDW = $clog2(NTHR),
  localparam int LAW  = $clog2(REGS_PER),
  localparam int GAW  = TIDW + LAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_valid,
  input  logic [TIDW-1:0] ld_tid,
  input  logic [PCW-1:0]  ld_pc,
  input  logic            mdone_valid,
  input  logic [TIDW-1:0] mdone_tid,
  input  logic            mreq,
  input  logic            yld,
  input  logic            step,
  output logic            run_valid,
  output logic [TIDW-1:0] run_tid,
  output logic [PCW-1:0]  fetch_pc,
  input  logic [GAW-1:0]  rd_addr,
  input  logic            rd_glb,
  output logic [DW-1:0]   rd_data,
  input  logic            wr_en,
  input  logic [GAW-1:0]  wr_addr,
  input  logic            wr_glb,
  input  logic [DW-1:0]   wr_data
);
  logic                     run_q;
  logic [TIDW-1:0]          cur_q;
  logic                     mreq_g, yld_g, step_g, swap, launch, found;
  logic [TIDW-1:0]          sel_idx;
  logic [NTHR-1:0]          ready, cand;
  logic [NTHR-1:0][PCW-1:0] pcs;
  logic [GAW-1:0]           rd_phys, wr_phys;

  assign mreq_g = run_q & mreq;
  assign yld_g  = run_q & yld & ~mreq;
  assign step_g = run_q & step & ~mreq & ~yld;
  assign swap   = ~run_q | mreq_g | yld_g;
  assign cand   = ready | (yld_g ? (NTHR'(1) << cur_q) : '0);
  assign launch = swap & found;

  ctx_rr_pick #(.NTHR(NTHR)) u_pick (
    .req(cand), .last(cur_q), .found(found), .idx(sel_idx)
  );

  ctx_thread_tbl #(.NTHR(NTHR), .PCW(PCW)) u_tbl (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_tid(ld_tid), .ld_pc(ld_pc),
    .done_valid(mdone_valid), .done_tid(mdone_tid),
    .cur(cur_q), .mreq_g(mreq_g), .yld_g(yld_g), .step_g(step_g),
    .launch(launch), .sel_idx(sel_idx),
    .ready(ready), .pcs(pcs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cur_q <= '0;
    end else if (launch) begin
      run_q <= 1'b1;
      cur_q <= sel_idx;
    end else if (mreq_g) begin
      run_q <= 1'b0;
    end
  end

  assign run_valid = run_q;
  assign run_tid   = cur_q;
  assign fetch_pc  = pcs[cur_q];

  assign rd_phys = rd_glb ? rd_addr : {cur_q, rd_addr[LAW-1:0]};
  assign wr_phys = wr_glb ? wr_addr : {cur_q, wr_addr[LAW-1:0]};

  ctx_regfile #(.DW(DW), .AW(GAW)) u_rf (
    .clk(clk), .we(wr_en), .waddr(wr_phys), .wdata(wr_data),
    .raddr(rd_phys), .rdata(rd_data)
  );
endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk #(
  parameter int NTHR = 4,
  parameter int PCW  = 11,
  localparam int TIDW = $clog2(NTHR)
) (
  input logic            clk,
  input logic            rst,
  input logic            mreq,
  input logic            yld,
  input logic            step,
  input logic            run_valid,
  input logic [TIDW-1:0] run_tid,
  input logic [PCW-1:0]  fetch_pc
);
  logic [PCW-1:0] pc_inc;
  assign pc_inc = fetch_pc + 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !run_valid); // R1

  AST_HOLD_THREAD: assert property (@(posedge clk) disable iff (rst)
    run_valid && !mreq && !yld |=> run_valid && run_tid == $past(run_tid)); // R13

  AST_STEP_PC: assert property (@(posedge clk) disable iff (rst)
    run_valid && step && !mreq && !yld |=> fetch_pc == $past(pc_inc)); // R4

  AST_SWAP_AWAY: assert property (@(posedge clk) disable iff (rst)
    run_valid && mreq |=> !run_valid || run_tid != $past(run_tid)); // R5

  AST_YIELD_GAPLESS: assert property (@(posedge clk) disable iff (rst)
    run_valid && yld && !mreq |=> run_valid); // R8
endmodule

bind ctx_sched ctx_sched_chk #(.NTHR(NTHR), .PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .mreq(mreq), .yld(yld), .step(step),
  .run_valid(run_valid), .run_tid(run_tid), .fetch_pc(fetch_pc)
);

// File: tb/ctx_sched_tb.sv
module ctx_sched_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 0, mdone_valid = 0, mreq = 0, yld = 0, step = 0;
  logic [1:0]  ld_tid = 0, mdone_tid = 0;
  logic [10:0] ld_pc = 0;
  logic        run_valid;
  logic [1:0]  run_tid;
  logic [10:0] fetch_pc;
  logic [6:0]  rd_addr = 0, wr_addr = 0;
  logic        rd_glb = 0, wr_glb = 0, wr_en = 0;
  logic [31:0] rd_data, wr_data = 0;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  localparam logic [31:0] VA = 32'hA5A5_0003;
  localparam logic [31:0] VB = 32'h0B0B_0010;
  localparam logic [31:0] VC = 32'hC0C0_0005;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_sched u_dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_tid(ld_tid), .ld_pc(ld_pc),
    .mdone_valid(mdone_valid), .mdone_tid(mdone_tid), .mreq(mreq), .yld(yld),
    .step(step), .run_valid(run_valid), .run_tid(run_tid), .fetch_pc(fetch_pc),
    .rd_addr(rd_addr), .rd_glb(rd_glb), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_glb(wr_glb), .wr_data(wr_data)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_ld(input logic [1:0] t, input logic [10:0] pc);
    ld_valid = 1; ld_tid = t; ld_pc = pc; tick(); ld_valid = 0;
  endtask
  task automatic pulse_done(input logic [1:0] t);
    mdone_valid = 1; mdone_tid = t; tick(); mdone_valid = 0;
  endtask
  task automatic pulse_mreq(); mreq = 1; tick(); mreq = 0; endtask
  task automatic pulse_yld();  yld = 1;  tick(); yld = 0;  endtask

  task automatic t_reset();
    rst = 1; repeat (3) tick(); rst = 0;
    chk("R1 idle after reset", run_valid, 0);
    tick();
    chk("R1 still idle", run_valid, 0);
  endtask

  task automatic t_load_start();
    pulse_ld(2'd0, 11'd100);
    chk("R3 not yet started", run_valid, 0);
    tick();
    chk("R3 started", run_valid, 1);
    chk("R3 tid", run_tid, 0);
    chk("R2 loaded pc", fetch_pc, 100);
    pulse_ld(2'd1, 11'd200);
    pulse_ld(2'd2, 11'd300);
    pulse_ld(2'd0, 11'd555);
    chk("R13 keeps engine", run_tid, 0);
    chk("R2 load to busy ignored", fetch_pc, 100);
  endtask

  task automatic t_step();
    step = 1; repeat (3) tick(); step = 0;
    chk("R4 pc advanced", fetch_pc, 103);
  endtask

  task automatic t_mreq_chain();
    pulse_mreq();
    chk("R5 swap valid", run_valid, 1);
    chk("R5 swap tid", run_tid, 1);
    chk("R5 swap pc", fetch_pc, 200);
    pulse_mreq();
    chk("R5 next tid", run_tid, 2);
    chk("R5 next pc", fetch_pc, 300);
    pulse_mreq();
    chk("R7 none ready", run_valid, 0);
  endtask

  task automatic t_done();
    pulse_done(2'd3);
    tick();
    chk("R9 done to idle thread ignored", run_valid, 0);
    pulse_done(2'd1);
    chk("R7 still stalled", run_valid, 0);
    tick();
    chk("R6 resume valid", run_valid, 1);
    chk("R6 resume tid", run_tid, 1);
    chk("R6 resume pc", fetch_pc, 201);
    pulse_done(2'd0);
    tick();
    chk("R13 no preemption", run_tid, 1);
    pulse_yld();
    chk("R8 yield to ready", run_tid, 0);
    chk("R6 resume pc t0", fetch_pc, 104);
  endtask

  task automatic t_yield();
    pulse_yld();
    chk("R8 yield rr tid", run_tid, 1);
    chk("R8 yield pc", fetch_pc, 202);
    pulse_mreq();
    chk("R5 rr wrap tid", run_tid, 0);
    chk("R8 yielded pc+1", fetch_pc, 105);
    pulse_yld();
    chk("R8 sole thread gapless", run_valid, 1);
    chk("R8 sole thread tid", run_tid, 0);
    chk("R8 sole thread pc", fetch_pc, 106);
  endtask

  task automatic t_wrap();
    pulse_ld(2'd3, 11'd2046);
    pulse_mreq();
    chk("R5 to thread 3", run_tid, 3);
    chk("R2 pc thread 3", fetch_pc, 2046);
    step = 1; repeat (2) tick(); step = 0;
    chk("R14 pc wraps", fetch_pc, 0);
  endtask

  task automatic t_regs();
    wr_en = 1; wr_glb = 0; wr_addr = 7'd5;  wr_data = VA; tick();
    wr_glb = 1; wr_addr = 7'd10; wr_data = VB; tick();
    wr_en = 0;
    rd_glb = 0; rd_addr = 7'd5; tick();
    chk("R12 R10 local read t3", rd_data, VA);
    rd_glb = 1; rd_addr = 7'd101; tick();
    chk("R11 global alias of t3 local", rd_data, VA);
    pulse_done(2'd0);
    pulse_yld();
    chk("R8 switch to t0", run_tid, 0);
    chk("R6 t0 resume pc", fetch_pc, 107);
    wr_en = 1; wr_glb = 0; wr_addr = 7'd5; wr_data = VC; tick();
    wr_en = 0;
    rd_glb = 0; rd_addr = 7'd5; tick();
    chk("R10 local read t0", rd_data, VC);
    rd_glb = 1; rd_addr = 7'd101; tick();
    chk("R10 t3 bank untouched", rd_data, VA);
    rd_glb = 0; rd_addr = 7'd10; tick();
    chk("R11 global write seen locally", rd_data, VB);
    rd_glb = 1; rd_addr = 7'd10; tick();
    chk("R11 global read", rd_data, VB);
  endtask

  initial begin
    tick();
    t_reset();
    t_load_start();
    t_step();
    t_mreq_chain();
    t_done();
    t_yield();
    t_wrap();
    t_regs();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule